// File: doc/BRIEF.md
# Frame-Flushed Pixel Capture FIFO

This block takes 8-bit pixels from the parallel output of a camera-link receiver and delivers them to a system clock domain as 64-bit words. On the pixel clock it samples the data bus at the rising edge. A byte is taken only while both the frame-valid and the line-valid strobes are high. Eight accepted bytes are packed into one word, with the first byte in the least significant lane. The word is written into an asynchronous FIFO. A processor reads that FIFO on the system clock, which is about 100 MHz in use. Each side reports its own view of the word occupancy. The write side also reports full and a sticky overflow flag. The read side reports empty.

A flush request on the pixel clock, normally raised once per frame during blanking, throws away everything still held. That covers the stored words and any half-packed word, so a new frame never starts behind stale data. The write side clears its packer at once. The read side learns of the flush through a synchronised toggle. It then moves its pointer up to the write pointer it has seen.

Top module: `clink_capture_fifo`

## Requirements
- R1: After reset, empty is 1, full is 0, overflow is 0, and both occupancy counts are 0.
- R2: Bytes are packed little-endian. The first accepted byte of a word appears in rd_data[7:0] and the eighth in rd_data[63:56].
- R3: A byte is accepted only at a rising pix_clk edge where fval and lval are both 1. Bytes presented with either strobe low are not stored.
- R4: A word becomes readable only once all eight of its bytes are accepted. Fewer than eight bytes leave empty at 1 and rd_count at 0.
- R5: Words are read in write order. A read is accepted when rd_en is 1 and empty is 0, and the word appears on rd_data one sys_clk cycle later.
- R6: rd_en while empty is 1 leaves rd_data unchanged and does not move the read pointer. The next word written is the next word read.
- R7: With DEPTH = 2^ADDR_W words stored, full is 1. Further completed words are dropped and set overflow, which stays 1 until pix_rst.
- R8: A one-cycle pulse on flush_req discards all stored words and any partial word. Once the pointers have crossed the clock domains, empty is 1 and both counts are 0. Later bytes start a new word in lane 0.
- R9: Once both domains have settled, wr_count and rd_count each equal the number of stored words, and neither ever exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pix_clk | input | 1 | Pixel clock, write side |
| pix_rst | input | 1 | Synchronous active-high reset, pixel domain |
| fval | input | 1 | Frame valid strobe |
| lval | input | 1 | Line valid strobe |
| pix_data | input | 8 | Pixel byte |
| flush_req | input | 1 | Per-frame discard request, pixel domain |
| sys_clk | input | 1 | System clock, read side |
| sys_rst | input | 1 | Synchronous active-high reset, system domain |
| rd_en | input | 1 | Read request |
| rd_data | output | 64 | Last word read |
| empty | output | 1 | No word available to read |
| full | output | 1 | Write side sees DEPTH words stored |
| overflow | output | 1 | Sticky: a completed word was dropped |
| wr_count | output | ADDR_W+1 | Word occupancy seen by the write side |
| rd_count | output | ADDR_W+1 | Word occupancy seen by the read side |

## Verification
Some rules are checked by assertions on every cycle of their own clock. Overflow never falls once set, and it can only rise out of a full state. A read against an empty FIFO leaves rd_data still. Bytes outside an active line never advance the packing lane, a flush always returns the packer to lane 0, and neither occupancy count goes above DEPTH. The bench scenarios are needed for the rest: byte lane order within a word, word order through the clock crossing, where the full threshold falls, and whether a flush really removes both stored and half-packed data from what the processor later reads.

// File: rtl/clcap_pkg.sv
package clcap_pkg;
  localparam int PIX_W  = 8;
  localparam int LANES  = 8;
  localparam int WORD_W = PIX_W * LANES;
  localparam int LANE_W = $clog2(LANES);
  typedef logic [PIX_W-1:0]  pix_t;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/clcap_sync.sv
module clcap_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage <= '0;
      q     <= '0;
    end else begin
      stage <= d;
      q     <= stage;
    end
  end
endmodule

// File: rtl/clcap_packer.sv
module clcap_packer
  import clcap_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              fval,
  input  logic              lval,
  input  pix_t              din,
  input  logic              flush,
  output logic              word_valid,
  output word_t             word,
  output logic [LANE_W-1:0] lane
);
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

  logic take;
  assign take = fval && lval && !flush;

  always_ff @(posedge clk) begin
    if (rst) begin
      lane       <= '0;
      word       <= '0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= take && (lane == LAST_LANE);
      if (flush) begin
        lane <= '0;
      end else if (take) begin
        word[lane*PIX_W +: PIX_W] <= din;
        lane <= lane + 1'b1;
      end
    end
  end
endmodule

// File: rtl/clcap_wr_ctrl.sv
module clcap_wr_ctrl #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              flush,
  input  logic [ADDR_W:0]   rgray_s,
  output logic              mem_we,
  output logic [ADDR_W-1:0] waddr,
  output logic [ADDR_W:0]   wgray,
  output logic              full,
  output logic              overflow,
  output logic [ADDR_W:0]   wr_count,
  output logic              flush_tgl
);
  localparam int PW = ADDR_W + 1;
  localparam logic [PW-1:0] DEPTH_V = PW'(2 ** ADDR_W);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] wbin, wbin_nx, cnt_nx;
  logic          want;

  assign want    = push && !flush;
  assign mem_we  = want && !full;
  assign waddr   = wbin[ADDR_W-1:0];
  assign wbin_nx = wbin + PW'(mem_we);
  assign cnt_nx  = wbin_nx - g2b(rgray_s);

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin      <= '0;
      wgray     <= '0;
      full      <= 1'b0;
      overflow  <= 1'b0;
      wr_count  <= '0;
      flush_tgl <= 1'b0;
    end else begin
      wbin      <= wbin_nx;
      wgray     <= wbin_nx ^ (wbin_nx >> 1);
      full      <= (cnt_nx == DEPTH_V);
      wr_count  <= cnt_nx;
      overflow  <= overflow | (want && full);
      flush_tgl <= flush_tgl ^ flush;
    end
  end
endmodule

// File: rtl/clcap_rd_ctrl.sv
module clcap_rd_ctrl #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W:0]   wgray_s,
  input  logic              flush_tgl_s,
  output logic              rd_do,
  output logic [ADDR_W-1:0] raddr,
  output logic [ADDR_W:0]   rgray,
  output logic              empty,
  output logic [ADDR_W:0]   rd_count
);
  localparam int PW = ADDR_W + 1;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] rbin, rbin_nx, wbin_s, cnt_nx;
  logic          tgl_d, flush_seen;

  assign flush_seen = flush_tgl_s ^ tgl_d;
  assign rd_do      = rd_en && !empty && !flush_seen;
  assign raddr      = rbin[ADDR_W-1:0];
  assign wbin_s     = g2b(wgray_s);
  assign rbin_nx    = flush_seen ? wbin_s : rbin + PW'(rd_do);
  assign cnt_nx     = wbin_s - rbin_nx;

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin     <= '0;
      rgray    <= '0;
      empty    <= 1'b1;
      rd_count <= '0;
      tgl_d    <= 1'b0;
    end else begin
      rbin     <= rbin_nx;
      rgray    <= rbin_nx ^ (rbin_nx >> 1);
      empty    <= (cnt_nx == '0);
      rd_count <= cnt_nx;
      tgl_d    <= flush_tgl_s;
    end
  end
endmodule

// File: rtl/clink_capture_fifo.sv
module clink_capture_fifo
  import clcap_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              pix_clk,
  input  logic              pix_rst,
  input  logic              fval,
  input  logic              lval,
  input  logic [PIX_W-1:0]  pix_data,
  input  logic              flush_req,
  input  logic              sys_clk,
  input  logic              sys_rst,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data,
  output logic              empty,
  output logic              full,
  output logic              overflow,
  output logic [ADDR_W:0]   wr_count,
  output logic [ADDR_W:0]   rd_count
);
  localparam int DEPTH = 2 ** ADDR_W;
  localparam int PW    = ADDR_W + 1;

  word_t              pk_word;
  logic               pk_valid;
  logic [LANE_W-1:0]  pk_idx;
  logic               mem_we, rd_do, flush_tgl, flush_tgl_s;
  logic [ADDR_W-1:0]  waddr, raddr;
  logic [PW-1:0]      wgray, rgray, wgray_s, rgray_s;

  word_t mem [DEPTH];

  clcap_packer u_packer (
    .clk(pix_clk), .rst(pix_rst), .fval(fval), .lval(lval), .din(pix_data),
    .flush(flush_req), .word_valid(pk_valid), .word(pk_word), .lane(pk_idx)
  );

  clcap_wr_ctrl #(.ADDR_W(ADDR_W)) u_wr (
    .clk(pix_clk), .rst(pix_rst), .push(pk_valid), .flush(flush_req),
    .rgray_s(rgray_s), .mem_we(mem_we), .waddr(waddr), .wgray(wgray),
    .full(full), .overflow(overflow), .wr_count(wr_count), .flush_tgl(flush_tgl)
  );

  clcap_sync #(.W(PW)) u_sync_r2w (
    .clk(pix_clk), .rst(pix_rst), .d(rgray), .q(rgray_s)
  );

  clcap_sync #(.W(PW)) u_sync_w2r (
    .clk(sys_clk), .rst(sys_rst), .d(wgray), .q(wgray_s)
  );

  clcap_sync #(.W(1)) u_sync_flush (
    .clk(sys_clk), .rst(sys_rst), .d(flush_tgl), .q(flush_tgl_s)
  );

  clcap_rd_ctrl #(.ADDR_W(ADDR_W)) u_rd (
    .clk(sys_clk), .rst(sys_rst), .rd_en(rd_en), .wgray_s(wgray_s),
    .flush_tgl_s(flush_tgl_s), .rd_do(rd_do), .raddr(raddr), .rgray(rgray),
    .empty(empty), .rd_count(rd_count)
  );

  always_ff @(posedge pix_clk) begin
    if (mem_we) mem[waddr] <= pk_word;
  end

  always_ff @(posedge sys_clk) begin
    if (sys_rst)    rd_data <= '0;
    else if (rd_do) rd_data <= mem[raddr];
  end
endmodule

// File: rtl/clink_capture_fifo_chk.sv
module clink_capture_fifo_chk
  import clcap_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input logic              pix_clk,
  input logic              pix_rst,
  input logic              sys_clk,
  input logic              sys_rst,
  input logic              fval,
  input logic              lval,
  input logic              flush_req,
  input logic              rd_en,
  input logic              empty,
  input logic              full,
  input logic              overflow,
  input logic [WORD_W-1:0] rd_data,
  input logic [ADDR_W:0]   wr_count,
  input logic [ADDR_W:0]   rd_count,
  input logic [LANE_W-1:0] pk_idx
);
  localparam logic [ADDR_W:0] DEPTH_V = (ADDR_W+1)'(2 ** ADDR_W);

  AST_OVF_STICKY: assert property (@(posedge pix_clk) disable iff (pix_rst)
    overflow |=> overflow); // R7
  AST_OVF_FROM_FULL: assert property (@(posedge pix_clk) disable iff (pix_rst)
    $rose(overflow) |-> $past(full)); // R7
  AST_EMPTY_READ_HOLDS: assert property (@(posedge sys_clk) disable iff (sys_rst)
    (rd_en && empty) |=> $stable(rd_data)); // R6
  AST_IDLE_NO_PACK: assert property (@(posedge pix_clk) disable iff (pix_rst)
    (!(fval && lval) && !flush_req) |=> $stable(pk_idx)); // R3
  AST_FLUSH_LANE_ZERO: assert property (@(posedge pix_clk) disable iff (pix_rst)
    flush_req |=> (pk_idx == '0)); // R8
  AST_RD_COUNT_RANGE: assert property (@(posedge sys_clk) disable iff (sys_rst)
    rd_count <= DEPTH_V); // R9
  AST_WR_COUNT_RANGE: assert property (@(posedge pix_clk) disable iff (pix_rst)
    wr_count <= DEPTH_V); // R9
endmodule

bind clink_capture_fifo clink_capture_fifo_chk #(.ADDR_W(ADDR_W)) u_chk (
  .pix_clk(pix_clk), .pix_rst(pix_rst), .sys_clk(sys_clk), .sys_rst(sys_rst),
  .fval(fval), .lval(lval), .flush_req(flush_req), .rd_en(rd_en),
  .empty(empty), .full(full), .overflow(overflow), .rd_data(rd_data),
  .wr_count(wr_count), .rd_count(rd_count), .pk_idx(pk_idx)
);

// File: tb/clink_capture_fifo_bench.sv
`timescale 1ns/1ps
module clink_capture_fifo_bench;
  localparam int AW    = 4;
  localparam int DEPTH = 2 ** AW;

  logic          pix_clk = 1'b0, sys_clk = 1'b0;
  logic          pix_rst = 1'b1, sys_rst = 1'b1;
  logic          fval = 1'b0, lval = 1'b0, flush_req = 1'b0, rd_en = 1'b0;
  logic [7:0]    pix_data = '0;
  logic [63:0]   rd_data;
  logic          empty, full, overflow;
  logic [AW:0]   wr_count, rd_count;

  int n_chk = 0, n_fail = 0;

  logic [63:0] mq[$];
  logic [63:0] m_part = '0;
  int          m_idx = 0;
  logic [63:0] last_rd = '0;

  always #15 pix_clk = ~pix_clk;
  always #4  sys_clk = ~sys_clk;

  clink_capture_fifo #(.ADDR_W(AW)) u_clink_capture_fifo (
    .pix_clk(pix_clk), .pix_rst(pix_rst), .fval(fval), .lval(lval),
    .pix_data(pix_data), .flush_req(flush_req), .sys_clk(sys_clk),
    .sys_rst(sys_rst), .rd_en(rd_en), .rd_data(rd_data), .empty(empty),
    .full(full), .overflow(overflow), .wr_count(wr_count), .rd_count(rd_count)
  );

  // behavioural reference for the write side
  always @(posedge pix_clk) begin
    if (pix_rst) begin
      m_idx = 0; mq.delete();
    end else if (flush_req) begin
      m_idx = 0; mq.delete();
    end else if (fval && lval) begin
      m_part[m_idx*8 +: 8] = pix_data;
      m_idx++;
      if (m_idx == 8) begin
        m_idx = 0;
        if (mq.size() < DEPTH) mq.push_back(m_part);
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic send_byte(input logic [7:0] b, input logic fv, input logic lv);
    @(negedge pix_clk);
    fval = fv; lval = lv; pix_data = b;
  endtask

  task automatic idle_pix(input int n);
    for (int i = 0; i < n; i++) send_byte(8'h00, 1'b0, 1'b0);
  endtask

  task automatic send_word(input logic [63:0] w);
    for (int i = 0; i < 8; i++) send_byte(w[i*8 +: 8], 1'b1, 1'b1);
  endtask

  task automatic settle();
    idle_pix(2);
    repeat (40) @(negedge sys_clk);
  endtask

  task automatic drain(input string tag);
    logic [63:0] e = '0;
    bit did = 0;
    int idle = 0;
    for (int k = 0; k < 5000; k++) begin
      @(negedge sys_clk);
      if (did) begin
        check(rd_data === e, tag, rd_data, e);
        last_rd = rd_data;
        did = 0;
      end
      if (!empty) begin
        rd_en = 1'b1;
        if (mq.size() == 0) begin
          check(1'b0, {tag, " extra word"}, 64'd1, 64'd0);
          e = 'x;
        end else e = mq.pop_front();
        did = 1; idle = 0;
      end else begin
        rd_en = 1'b0;
        idle++;
        if (idle > 120) break;
      end
    end
    rd_en = 1'b0;
    check(mq.size() == 0, {tag, " words left"}, 64'(mq.size()), 64'd0);
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
  end

  initial begin
    repeat (5) @(negedge pix_clk);
    // R1 reset values
    check(empty === 1'b1, "R1 empty", 64'(empty), 64'd1);
    check(full === 1'b0, "R1 full", 64'(full), 64'd0);
    check(overflow === 1'b0, "R1 overflow", 64'(overflow), 64'd0);
    check(rd_count === '0, "R1 rd_count", 64'(rd_count), 64'd0);
    check(wr_count === '0, "R1 wr_count", 64'(wr_count), 64'd0);
    pix_rst = 1'b0;
    @(negedge sys_clk); sys_rst = 1'b0;
    idle_pix(3);

    // R2 lane order
    send_word(64'h0807060504030201);
    settle();
    check(mq.size() == 1 && mq[0] == 64'h0807060504030201, "R2 model", mq[0],
          64'h0807060504030201);
    drain("R2 little-endian");

    // R3 strobes gate capture
    send_byte(8'hA0, 1'b1, 1'b1);
    send_byte(8'hEE, 1'b1, 1'b0);
    send_byte(8'hA1, 1'b1, 1'b1);
    send_byte(8'hEF, 1'b0, 1'b1);
    send_byte(8'hED, 1'b0, 1'b0);
    for (int i = 2; i < 8; i++) send_byte(8'hA0 + 8'(i), 1'b1, 1'b1);
    settle();
    check(rd_count === 1, "R3 one word", 64'(rd_count), 64'd1);
    drain("R3 gated bytes");
    check(last_rd === 64'hA7A6A5A4A3A2A1A0, "R3 word", last_rd, 64'hA7A6A5A4A3A2A1A0);

    // R4 partial word stays invisible
    for (int i = 0; i < 5; i++) send_byte(8'h10 + 8'(i), 1'b1, 1'b1);
    settle();
    check(empty === 1'b1, "R4 empty after 5 bytes", 64'(empty), 64'd1);
    check(rd_count === 0, "R4 rd_count", 64'(rd_count), 64'd0);
    for (int i = 5; i < 8; i++) send_byte(8'h10 + 8'(i), 1'b1, 1'b1);
    settle();
    check(empty === 1'b0, "R4 word after 8 bytes", 64'(empty), 64'd0);
    drain("R4 completed word");

    // R6 empty reads
    @(negedge sys_clk); rd_en = 1'b1;
    repeat (4) @(negedge sys_clk);
    check(rd_data === last_rd, "R6 data held", rd_data, last_rd);
    check(empty === 1'b1, "R6 still empty", 64'(empty), 64'd1);
    rd_en = 1'b0;
    send_word(64'h1122334455667788);
    settle();
    drain("R6 pointer not moved");

    // R9 counts
    for (int i = 0; i < 5; i++) send_word(64'hC000 + 64'(i));
    settle();
    check(rd_count === 5, "R9 rd_count", 64'(rd_count), 64'd5);
    check(wr_count === 5, "R9 wr_count", 64'(wr_count), 64'd5);
    drain("R9 drain");
    settle();
    check(wr_count === 0, "R9 wr_count drained", 64'(wr_count), 64'd0);

    // R5 order with concurrent write and read
    fork
      for (int i = 0; i < 12; i++) begin
        send_word({32'hFACE0000, 32'(i * 7)});
        idle_pix(i % 3);
      end
      drain("R5 streaming order");
    join

    // R8 flush drops stored and partial data
    for (int i = 0; i < 3; i++) send_word(64'hDEAD0000 + 64'(i));
    for (int i = 0; i < 3; i++) send_byte(8'h55, 1'b1, 1'b1);
    settle();
    check(rd_count === 3, "R8 before flush", 64'(rd_count), 64'd3);
    @(negedge pix_clk); fval = 1'b0; lval = 1'b0; flush_req = 1'b1;
    @(negedge pix_clk); flush_req = 1'b0;
    settle();
    check(empty === 1'b1, "R8 empty after flush", 64'(empty), 64'd1);
    check(rd_count === 0, "R8 rd_count", 64'(rd_count), 64'd0);
    check(wr_count === 0, "R8 wr_count", 64'(wr_count), 64'd0);
    send_word(64'h0F0E0D0C0B0A0908);
    send_word(64'h8899AABBCCDDEEFF);
    settle();
    drain("R8 after flush");

    // R7 full and sticky overflow
    for (int i = 0; i < DEPTH + 4; i++) send_word(64'hB0B0000000000000 + 64'(i));
    settle();
    check(full === 1'b1, "R7 full", 64'(full), 64'd1);
    check(overflow === 1'b1, "R7 overflow", 64'(overflow), 64'd1);
    check(rd_count === DEPTH, "R7 rd_count", 64'(rd_count), 64'(DEPTH));
    drain("R7 first DEPTH words");
    settle();
    check(full === 1'b0, "R7 full cleared", 64'(full), 64'd0);
    check(overflow === 1'b1, "R7 overflow sticky", 64'(overflow), 64'd1);

    report();
  end
endmodule